// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block takes one asynchronous serial line and turns each frame on it into a byte that a bus can read. The frame is fixed: a low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. The block has no bit-rate divider of its own. All bit timing comes from an enable input that is high for one clock cycle at sixteen times the bit rate. The line passes through a two-flop synchronizer. A falling edge is then confirmed at the middle of the start bit, and every later bit is sampled at its centre.

The finished byte goes into a one-entry holding register. `byte_ready` is high while a byte waits to be read. `frame_err` describes the stop bit of the byte now held. `overrun` shows that a byte arrived while the previous one was still unread. A bus read is `sel` high with `wr_en` low. It returns the held byte and consumes it. The `clear` input empties the holding register, drops all flags and aborts any frame in progress.

Top module: `serial_byte_rx`

## Requirements
- R1: The serial input goes through two synchronizing flops, so a change on `rxd` is first seen by the sampler at the third rising clock edge after the change.
- R2: A start bit is accepted only if the synchronized line is still low at the 8th enable tick after the tick that saw it go low. Otherwise the receiver returns to idle and produces no byte.
- R3: After an accepted start, each data bit is sampled every 16 enable ticks and placed least significant bit first. The byte appears on `rd_data` once loaded.
- R4: `byte_ready` goes high in the clock after the enable tick that samples the stop bit. It stays high until the byte is read or cleared.
- R5: `frame_err` is 1 when the stop bit of the held byte was sampled low and 0 when it was sampled high. It keeps its value through a read and is replaced only when the next byte is loaded.
- R6: `overrun` is set when a byte completes while `byte_ready` is high and no read happens in that cycle. A read clears it.
- R7: A read (`sel`=1, `wr_en`=0) clears `byte_ready` at the next edge. `sel`=1 with `wr_en`=1 changes nothing.
- R8: `clear` takes priority over everything else. At the next edge `byte_ready`, `frame_err` and `overrun` are 0, `rd_data` is 0x00 and any frame in progress is dropped.
- R9: While `rst` is high all outputs go to 0 and the line is taken as idle (high). Without an enable tick the receive state machine does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| sel | input | 1 | Bus select of the data register |
| wr_en | input | 1 | Bus write strobe; reads need it low |
| clear | input | 1 | Synchronous clear of receiver and flags |
| rd_data | output | 8 | Held byte |
| byte_ready | output | 1 | A byte waits to be read |
| frame_err | output | 1 | Stop bit of held byte was low |
| overrun | output | 1 | A byte arrived while the last was unread |

## Verification
A behavioural model in the bench carries the line delay, the tick phase counter and the holding state as integers. It is updated on the same rising edge as the design and compared at the following falling edge. The flags and `rd_data` are therefore checked in the exact cycle they are due. The loaded byte and its flags are due one clock after the stop-sample tick. A read or a `clear` takes effect one clock after the edge that sees it. A line edge reaches the sampler two clocks late. Named checks at frame, read and clear boundaries confirm the corner cases on top of the per-cycle comparison.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int RX_DATA_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [RX_DATA_BITS-1:0] data;
        logic                    stop_bit;
    } rx_frame_t;

    function automatic logic [RX_DATA_BITS-1:0] shift_in_msb(
        input logic [RX_DATA_BITS-1:0] cur, input logic bit_in);
        return {bit_in, cur[RX_DATA_BITS-1:1]};
    endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      tick,
    input  logic      line,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int BIT_W  = $clog2(RX_DATA_BITS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE/2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(RX_DATA_BITS - 1);

    rx_state_e                state;
    logic [CNT_W-1:0]         cnt;
    logic [BIT_W-1:0]         bit_idx;
    logic [RX_DATA_BITS-1:0]  shreg;

    assign done        = tick && !clear && state == ST_STOP && cnt == FULL_LAST;
    assign frame.data  = shreg;
    assign frame.stop_bit = line;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            if (rst) shreg <= '0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (!line) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= line ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == FULL_LAST) begin
                        cnt   <= '0;
                        shreg <= shift_in_msb(shreg, line);
                        if (bit_idx == BIT_LAST) state <= ST_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == FULL_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(state));

    // R2
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear && state == ST_START && cnt == HALF_LAST && line) |=> state == ST_IDLE);

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> state == ST_IDLE);
endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import rx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    load,
    input  rx_frame_t               frame,
    input  logic                    rd,
    output logic [RX_DATA_BITS-1:0] data,
    output logic                    present,
    output logic                    ferr,
    output logic                    ovr
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data    <= '0;
            present <= 1'b0;
            ferr    <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            present <= load | (present & ~rd);
            ovr     <= (ovr & ~rd) | (load & present & ~rd);
            if (load) begin
                data <= frame.data;
                ferr <= ~frame.stop_bit;
            end
        end
    end

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> present);

    // R7
    consume_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !load && !clear) |=> !present);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!present && !ovr && !ferr && data == '0));

    // R6
    overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(present));
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       sel,
    input  logic       wr_en,
    input  logic       clear,
    output logic [7:0] rd_data,
    output logic       byte_ready,
    output logic       frame_err,
    output logic       overrun
);
    logic      line_s;
    logic      done;
    rx_frame_t frame;
    logic      rd;

    assign rd = sel & ~wr_en;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(line_s)
    );

    rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk  (clk),
        .rst  (rst),
        .clear(clear),
        .tick (tick16),
        .line (line_s),
        .done (done),
        .frame(frame)
    );

    rx_holding u_hold (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .load   (done),
        .frame  (frame),
        .rd     (rd),
        .data   (rd_data),
        .present(byte_ready),
        .ferr   (frame_err),
        .ovr    (overrun)
    );
endmodule

// File: tb/sim_serial_byte_rx.sv
module sim_serial_byte_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0;
    logic rxd = 1'b1;
    logic sel = 1'b0;
    logic wr_en = 1'b0;
    logic clear = 1'b0;
    logic [7:0] rd_data;
    logic byte_ready, frame_err, overrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tcnt = 0;

    always #10 clk = ~clk;

    serial_byte_rx u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .sel(sel),
        .wr_en(wr_en), .clear(clear), .rd_data(rd_data),
        .byte_ready(byte_ready), .frame_err(frame_err), .overrun(overrun)
    );

    // tick every 4 clocks
    always @(posedge clk) begin
        #2;
        tick16 = (tcnt == 3);
        tcnt = (tcnt + 1) % 4;
    end

    // behavioural reference
    int m_s1, m_s2, m_phase, m_cnt, m_bits, m_line, m_done;
    logic [7:0] m_shift, m_buf;
    int m_ready, m_ferr, m_ovr, m_rd;
    initial begin
        m_s1 = 1; m_s2 = 1; m_phase = 0; m_cnt = 0; m_bits = 0;
        m_shift = 0; m_buf = 0; m_ready = 0; m_ferr = 0; m_ovr = 0;
    end

    always @(posedge clk) begin
        m_line = m_s2;
        m_done = 0;
        m_rd = (sel && !wr_en) ? 1 : 0;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_phase = 0; m_cnt = 0; m_bits = 0;
            m_shift = 0; m_buf = 0; m_ready = 0; m_ferr = 0; m_ovr = 0;
        end else begin
            if (clear) begin
                m_phase = 0; m_cnt = 0; m_bits = 0;
            end else if (tick16) begin
                if (m_phase == 0) begin
                    if (m_line == 0) begin m_phase = 1; m_cnt = 0; end
                end else if (m_phase == 1) begin
                    if (m_cnt == 7) begin
                        m_cnt = 0; m_bits = 0;
                        m_phase = m_line ? 0 : 2;
                    end else m_cnt++;
                end else if (m_phase == 2) begin
                    if (m_cnt == 15) begin
                        m_cnt = 0;
                        m_shift = {m_line[0], m_shift[7:1]};
                        if (m_bits == 7) m_phase = 3; else m_bits++;
                    end else m_cnt++;
                end else begin
                    if (m_cnt == 15) begin
                        m_cnt = 0; m_phase = 0; m_done = 1;
                    end else m_cnt++;
                end
            end
            if (clear) begin
                m_buf = 0; m_ready = 0; m_ferr = 0; m_ovr = 0;
            end else begin
                if (m_done) begin
                    if (m_ready && !m_rd) m_ovr = 1;
                    else if (m_rd) m_ovr = 0;
                    m_buf = m_shift; m_ferr = m_line ? 0 : 1; m_ready = 1;
                end else if (m_rd) begin
                    m_ready = 0; m_ovr = 0;
                end
            end
            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison: R1 R3 (data path timing), R4, R5, R6
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(rd_data == m_buf, "R1 R3 rd_data", rd_data, m_buf);
            chk(byte_ready == m_ready[0], "R4 byte_ready", byte_ready, m_ready);
            chk(frame_err == m_ferr[0], "R5 frame_err", frame_err, m_ferr);
            chk(overrun == m_ovr[0], "R6 overrun", overrun, m_ovr);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic send(input logic [7:0] b, input logic stop_val, input int stop_ticks);
        rxd = 1'b0; step(64);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; step(64); end
        rxd = stop_val; step(stop_ticks * 4);
        rxd = 1'b1; step(40);
    endtask

    task automatic do_read;
        sel = 1'b1; wr_en = 1'b0; step(1); sel = 1'b0;
    endtask

    initial begin
        step(5);
        @(negedge clk);
        chk(byte_ready == 0 && frame_err == 0 && overrun == 0, "R9 reset flags",
            {byte_ready, frame_err, overrun}, 0);
        chk(rd_data == 8'h00, "R9 reset data", rd_data, 0);
        step(1); rst = 1'b0; step(10);

        send(8'hA5, 1'b1, 16);
        @(negedge clk);
        chk(byte_ready == 1, "R4 ready after frame", byte_ready, 1);
        chk(rd_data == 8'hA5, "R3 byte A5", rd_data, 8'hA5);
        chk(frame_err == 0, "R5 good stop", frame_err, 0);
        step(1); sel = 1'b1; wr_en = 1'b1; step(1); sel = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk(byte_ready == 1, "R7 write ignored", byte_ready, 1);
        step(1); do_read;
        @(negedge clk);
        chk(byte_ready == 0, "R7 read consumes", byte_ready, 0);

        step(1); rxd = 1'b0; step(12); rxd = 1'b1; step(120);
        @(negedge clk);
        chk(byte_ready == 0, "R2 glitch rejected", byte_ready, 0);

        step(1); send(8'h3C, 1'b0, 10);
        @(negedge clk);
        chk(frame_err == 1, "R5 low stop", frame_err, 1);
        chk(rd_data == 8'h3C, "R3 byte 3C", rd_data, 8'h3C);
        step(1); do_read;
        @(negedge clk);
        chk(frame_err == 1, "R5 kept through read", frame_err, 1);
        step(1); send(8'h81, 1'b1, 16);
        @(negedge clk);
        chk(frame_err == 0, "R5 replaced on load", frame_err, 0);
        chk(rd_data == 8'h81, "R3 byte 81", rd_data, 8'h81);
        step(1); do_read;

        step(1); send(8'h11, 1'b1, 16); send(8'h22, 1'b1, 16);
        @(negedge clk);
        chk(overrun == 1, "R6 overrun set", overrun, 1);
        chk(rd_data == 8'h22, "R3 newest byte", rd_data, 8'h22);
        step(1); do_read;
        @(negedge clk);
        chk(overrun == 0 && byte_ready == 0, "R6 read clears", {overrun, byte_ready}, 0);

        step(1); send(8'h5A, 1'b0, 10);
        step(1); clear = 1'b1; step(1); clear = 1'b0;
        @(negedge clk);
        chk(byte_ready == 0 && frame_err == 0, "R8 clear flags", {byte_ready, frame_err}, 0);
        chk(rd_data == 8'h00, "R8 clear data", rd_data, 0);

        step(1); rxd = 1'b0; step(64); rxd = 1'b1; step(192);
        clear = 1'b1; step(1); clear = 1'b0; step(900);
        @(negedge clk);
        chk(byte_ready == 0, "R8 frame aborted", byte_ready, 0);

        step(1); send(8'h00, 1'b1, 16);
        @(negedge clk);
        chk(rd_data == 8'h00 && byte_ready == 1, "R3 byte 00", rd_data, 0);
        step(1); do_read; step(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule